// File: doc/BRIEF.md
# Bidirectional Parallel/Serial Bus Register

This block is an eight-bit storage register placed between two bidirectional 8-bit buses, A and B. It can copy a word from either bus to the other, hold a word by feeding each stage back into itself, take serial data in one bit at a time and show it in parallel on either bus, or capture a parallel word that is later shifted. Each bus is represented by separate input, output and output-enable vectors, so that the tri-state drivers sit outside the block.

All state runs on a fast system clock. The slower register clock is an ordinary input. It is synchronised through two flip-flops, and only its rising transitions count as register clock events. The direction input picks which bus supplies data and which one receives it. The A-bus enable gates the A drivers, and in A-to-B parallel mode it also chooses between loading from A and recirculating. The asynchronous select makes parallel loads follow the level instead of the edge. It has no effect in serial mode.

A parallel load on a register clock edge reaches the outputs on the third system-clock edge after the register clock is sampled high. Two of those edges are spent in synchronisation and one in the load. A level-sensitive load reaches the outputs one system-clock edge after its conditions are applied.

Top module: `bus_xfer_reg`

## Requirements
- R1: With `par_mode`=1, `async_sel`=0 and `dir_ab`=0, the register captures `b_in` once on each rising edge of `reg_clk`. It keeps its contents while no such edge occurs, and the contents are presented on `a_out`.
- R2: With `par_mode`=1 and `async_sel`=1, the register loads from the input bus on every system-clock cycle, whether or not `reg_clk` toggles. The input bus is B when `dir_ab`=0, and it is A when `dir_ab`=1 and `a_en`=1.
- R3: With `dir_ab`=1 and `a_en`=1 in parallel mode, `a_in` is loaded and shown on `b_out`. Outside reset, `b_oe` is all ones when `dir_ab`=1 and all zeros when `dir_ab`=0, and `a_oe` and `b_oe` are never both non-zero.
- R4: `a_oe` is all ones only when `dir_ab`=0, `a_en`=1 and reset is released. In every other case it is all zeros.
- R5: With `par_mode`=1, `dir_ab`=1 and `a_en`=0, `a_in` is ignored and every stage keeps its value. This holds on register clock edges and when `async_sel`=1.
- R6: With `par_mode`=0, each rising edge of `reg_clk` moves bit i to bit i+1 and puts `ser_in` into bit 0. Both parallel inputs are ignored.
- R7: With `par_mode`=0, `async_sel`=1 has no effect. Without a `reg_clk` rising edge the contents stay unchanged.
- R8: While `rst_n` is low on a system-clock edge, all stages clear to zero. While `rst_n` is low, `a_oe` and `b_oe` are zero.
- R9: A `reg_clk` level held high for many system-clock cycles counts as exactly one register clock event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_clk | input | 1 | Register clock, asynchronous to `clk` |
| a_en | input | 1 | A-bus driver enable; also selects recirculation |
| async_sel | input | 1 | 1 = level-sensitive parallel load |
| dir_ab | input | 1 | 1 = A is input and B is output; 0 = the reverse |
| par_mode | input | 1 | 1 = parallel mode, 0 = serial mode |
| ser_in | input | 1 | Serial data into bit 0 |
| a_in | input | 8 | A-bus receive data |
| b_in | input | 8 | B-bus receive data |
| a_out | output | 8 | A-bus drive data |
| a_oe | output | 8 | A-bus per-bit output enable |
| b_out | output | 8 | B-bus drive data |
| b_oe | output | 8 | B-bus per-bit output enable |

## Verification
The assertions assume that the mode inputs (`par_mode`, `dir_ab`, `a_en`, `async_sel`) and the data inputs are stable at each system-clock edge. They also assume that `reg_clk` stays high or low for at least three system clocks, so that the synchroniser can see every transition. The bench changes every input only on the falling system-clock edge. It holds each `reg_clk` level for four or more cycles and changes the mode controls only while `reg_clk` is low and the synchroniser has settled. Results are sampled one falling edge after the load that the latency count predicts.

// File: rtl/bus_xfer_pkg.sv
package bus_xfer_pkg;
    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_LOAD_A = 3'd1,
        OP_LOAD_B = 3'd2,
        OP_RECIRC = 3'd3,
        OP_SHIFT  = 3'd4
    } op_e;
endpackage

// File: rtl/brg_edge_sync.sv
module brg_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = async_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign rise = st_q.s2 & ~st_q.prev;

    // R9: one rising level produces a single-cycle event
    p_rise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/brg_op_decode.sv
module brg_op_decode
    import bus_xfer_pkg::*;
(
    input  logic par_mode,
    input  logic async_sel,
    input  logic dir_ab,
    input  logic a_en,
    input  logic rise,
    output op_e  op
);
    logic par_fire;

    // Serial mode never looks at async_sel
    assign par_fire = async_sel | rise;

    always_comb begin
        op = OP_HOLD;
        if (!par_mode) begin
            if (rise) op = OP_SHIFT;
        end else if (par_fire) begin
            if (!dir_ab)   op = OP_LOAD_B;
            else if (a_en) op = OP_LOAD_A;
            else           op = OP_RECIRC;
        end
    end
endmodule

// File: rtl/brg_stages.sv
module brg_stages
    import bus_xfer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] data
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] data_d, data_q;
    logic [WIDTH-1:0] shift_src;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            if (gi == 0) begin : g_head
                assign shift_src[gi] = ser_in;
            end else begin : g_body
                assign shift_src[gi] = data_q[gi-1];
            end
        end
    endgenerate

    always_comb begin
        data_d = data_q;
        case (op)
            OP_LOAD_A: data_d = a_in;
            OP_LOAD_B: data_d = b_in;
            OP_RECIRC: data_d = data_q;
            OP_SHIFT:  data_d = shift_src;
            default:   data_d = data_q;
        endcase
        if (!rst_n) data_d = '0;
    end

    always_ff @(posedge clk) data_q <= data_d;

    assign data = data_q;

    p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SHIFT |=> data_q == {$past(data_q[MSB-1:0]), $past(ser_in)});

    p_recirc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_RECIRC |=> $stable(data_q));

    p_load_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOAD_B |=> data_q == $past(b_in));

    p_load_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOAD_A |=> data_q == $past(a_in));
endmodule

// File: rtl/brg_bus_drive.sv
module brg_bus_drive #(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             dir_ab,
    input  logic             a_en,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    logic drive_a, drive_b;

    assign drive_a = rst_n & ~dir_ab & a_en;
    assign drive_b = rst_n & dir_ab;

    assign a_out = data;
    assign b_out = data;
    assign a_oe  = {WIDTH{drive_a}};
    assign b_oe  = {WIDTH{drive_b}};
endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg
    import bus_xfer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_clk,
    input  logic             a_en,
    input  logic             async_sel,
    input  logic             dir_ab,
    input  logic             par_mode,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    logic             rise;
    op_e              op;
    logic [WIDTH-1:0] data;

    brg_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (reg_clk),
        .rise     (rise)
    );

    brg_op_decode u_dec (
        .par_mode  (par_mode),
        .async_sel (async_sel),
        .dir_ab    (dir_ab),
        .a_en      (a_en),
        .rise      (rise),
        .op        (op)
    );

    brg_stages #(.WIDTH(WIDTH)) u_stg (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .a_in   (a_in),
        .b_in   (b_in),
        .ser_in (ser_in),
        .data   (data)
    );

    brg_bus_drive #(.WIDTH(WIDTH)) u_drv (
        .rst_n  (rst_n),
        .dir_ab (dir_ab),
        .a_en   (a_en),
        .data   (data),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    p_reset_quiet_r8: assert property (@(posedge clk)
        !rst_n |-> (a_oe == '0 && b_oe == '0));

    p_one_driver_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe != '0) |-> (b_oe == '0));

    p_serial_async_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_mode && !rise) |=> $stable(b_out));
endmodule

// File: tb/sim_bus_xfer_reg.sv
module sim_bus_xfer_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_clk = 1'b0;
    logic       a_en = 1'b1;
    logic       async_sel = 1'b0;
    logic       dir_ab = 1'b0;
    logic       par_mode = 1'b1;
    logic       ser_in = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [7:0] a_out, a_oe, b_out, b_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q;

    always #10 clk = ~clk;

    bus_xfer_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_clk(reg_clk), .a_en(a_en),
        .async_sel(async_sel), .dir_ab(dir_ab), .par_mode(par_mode),
        .ser_in(ser_in), .a_in(a_in), .b_in(b_in), .a_out(a_out),
        .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Register clock event: high for hold cycles, then low long enough to settle
    task automatic pulse(input int hold);
        reg_clk = 1'b1;
        idle(hold);
        reg_clk = 1'b0;
        idle(4);
    endtask

    task automatic t_reset;
        idle(3);
        check("R8 a_oe in reset", a_oe, 8'h00);
        check("R8 b_oe in reset", b_oe, 8'h00);
        rst_n = 1'b1;
        idle(1);
        check("R8 cleared", a_out, 8'h00);
    endtask

    task automatic t_sync_b_to_a;
        dir_ab = 0; a_en = 1; par_mode = 1; async_sel = 0; b_in = 8'hA5;
        idle(4);
        check("R1 no edge no load", a_out, 8'h00);
        pulse(4);
        check("R1 load on edge", a_out, 8'hA5);
        check("R4 a_oe on", a_oe, 8'hFF);
        check("R3 b_oe off", b_oe, 8'h00);
        b_in = 8'h3C;
        idle(5);
        check("R1 hold between edges", a_out, 8'hA5);
        a_en = 0;
        idle(1);
        check("R4 a_oe off when disabled", a_oe, 8'h00);
        a_en = 1;
    endtask

    task automatic t_a_to_b;
        dir_ab = 1; a_en = 1; a_in = 8'h5A;
        idle(2);
        pulse(4);
        check("R3 a to b load", b_out, 8'h5A);
        check("R3 b_oe on", b_oe, 8'hFF);
        check("R4 a_oe off when A is input", a_oe, 8'h00);
    endtask

    task automatic t_recirc;
        a_en = 0; a_in = 8'hFF;
        pulse(4);
        check("R5 recirc on edge", b_out, 8'h5A);
        async_sel = 1;
        idle(4);
        check("R5 recirc level mode", b_out, 8'h5A);
        async_sel = 0;
        a_en = 1;
        idle(1);
    endtask

    task automatic t_async;
        dir_ab = 0; a_en = 1; b_in = 8'hC3; async_sel = 1;
        idle(1);
        check("R2 level load", a_out, 8'hC3);
        b_in = 8'h81;
        idle(1);
        check("R2 follows each cycle", a_out, 8'h81);
        async_sel = 0; b_in = 8'h00;
        idle(4);
        check("R1 edge mode restored", a_out, 8'h81);
    endtask

    task automatic t_serial;
        dir_ab = 1; par_mode = 0; exp_q = 8'h81;
        a_in = 8'hEE; b_in = 8'h77;
        idle(2);
        ser_in = 1;
        pulse(12);
        exp_q = {exp_q[6:0], 1'b1};
        check("R9 long high one shift", b_out, exp_q);
        ser_in = 0;
        pulse(4);
        exp_q = {exp_q[6:0], 1'b0};
        check("R6 shift zero", b_out, exp_q);
        ser_in = 1;
        pulse(4);
        exp_q = {exp_q[6:0], 1'b1};
        check("R6 shift one", b_out, exp_q);
        async_sel = 1;
        idle(6);
        check("R7 async ignored serial", b_out, exp_q);
        async_sel = 0;
    endtask

    task automatic t_reset_mid;
        rst_n = 0;
        idle(1);
        check("R8 b_oe in reset", b_oe, 8'h00);
        rst_n = 1;
        idle(1);
        check("R8 cleared mid run", b_out, 8'h00);
    endtask

    initial begin
        t_reset();
        t_sync_b_to_a();
        t_a_to_b();
        t_recirc();
        t_async();
        t_serial();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule